// File: doc/BRIEF.md
# Feature Status Mailbox Controller

This block answers a host's request for the status word of a numbered feature through a small command mailbox. The host reaches three locations over a plain register bus that carries 64-bit reads and writes at byte offsets. The block keeps the mailbox's ownership and accepts one command at a time. After a fixed processing delay it looks the requested feature up in a local state table, then posts a result code and a packed response dword.

A transaction runs in four host steps. The host writes a command qword, which claims the mailbox for the in-band host. It then sets run-busy together with a packet length. Next it polls until run-busy drops and reads the result and the response. Last, it writes the completion bit, which frees the mailbox. The per-feature state table is filled through a separate configuration port. Each entry holds a present flag and five status flags.

Top module: `featstat_mbox`

## Requirements
- R1: After reset the status qword (offset 0x00), the command qword (0x08) and the response dword (0x0C) all read as zero.
- R2: A write to offset 0x08 while the owner field is 0 (none) latches the full 64-bit command, and from the next cycle the owner field (status bits 5:4) reads 1 (in-band host).
- R3: Writes that arrive out of turn are ignored. This covers a command write while the owner is not none, a run-busy write while the owner is not in-band, and any status write while run-busy is set.
- R4: A status write with bit 0 set while the owner is in-band and run-busy is clear sets run-busy and latches bits 31:16 as the packet length. It also clears the result code and the response dword.
- R5: Run-busy stays set for exactly LATENCY cycles (LATENCY at least 2) and then clears. The result code and the response take their final values one cycle before run-busy clears.
- R6: A command with opcode 0x10 in bits 7:0, a packet length of 2, and a feature ID in bits 48:40 that is below NUM_FEAT and names a present table entry ends with result code 0x40 in status bits 15:8.
- R7: On success the response dword carries the entry's flags. Bit 0 is enabled, bit 4 write-blocked, bit 5 read-blocked, bit 6 the out-of-band select, and bit 31 locked. Bits 15:8 echo the low byte of the feature ID. All other bits are zero.
- R8: Failures leave a zero response and one result code, chosen in this order of priority: 0x03 when the length is not 2, else 0x01 when the opcode is not 0x10, else 0x02 when the feature ID has no present entry (including any ID at or above NUM_FEAT).
- R9: A status write with bit 6 (completion) set while the owner is in-band and run-busy is clear returns the owner to none. It also clears the result, length and response. Completion takes priority over bit 0 in the same write.
- R10: A configuration write stores the present flag and the flags at the given entry. The flag bits are ordered: bit 0 enabled, 1 write-blocked, 2 read-blocked, 3 out-of-band select, 4 locked. It affects every later lookup.
- R11: The status qword reads {32'b0, length, result, 2'b0, owner, 3'b0, run-busy}, so the completion bit reads 0. Offset 0x0C reads the response in bits 31:0. Any other offset, or any cycle with the read strobe low, reads zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| bus_wr | input | 1 | Write strobe, one access per cycle |
| bus_rd | input | 1 | Read strobe; read data is combinational |
| bus_addr | input | 8 | Byte offset of the access |
| bus_wdata | input | 64 | Write data |
| bus_rdata | output | 64 | Read data, zero when not reading a mapped offset |
| cfg_we | input | 1 | Table entry write enable |
| cfg_idx | input | clog2(NUM_FEAT) | Table entry index |
| cfg_valid | input | 1 | Entry present flag to store |
| cfg_flags | input | 5 | Entry status flags to store (order in R10) |

## Verification
Successful lookups are run against entries with different flag mixes: all set, locked with enabled, and read-blocked with out-of-band select. These show that every flag lands in its own response bit and that the ID echo follows the request. Failing requests are sent with an absent entry, an ID just past the table, an ID whose ninth bit is set, a wrong opcode, and a wrong length, alone and combined. This separates the three error codes, checks their priority, and catches any truncation of the ID. Out-of-turn writes are sent at each ownership step: a second command, run-busy before ownership, completion while busy, and completion together with run-busy. A behavioural model checks the status word on every cycle against the expected sequence.

// File: rtl/featstat_pkg.sv
package featstat_pkg;

  localparam int unsigned BUS_DW = 64;
  localparam int unsigned BUS_AW = 8;

  // register offsets
  localparam logic [BUS_AW-1:0] OFS_STAT = 8'h00;
  localparam logic [BUS_AW-1:0] OFS_CMD  = 8'h08;
  localparam logic [BUS_AW-1:0] OFS_RESP = 8'h0C;

  // status qword field positions
  localparam int unsigned ST_RB_BIT  = 0;
  localparam int unsigned ST_OWN_LO  = 4;
  localparam int unsigned ST_OWN_HI  = 5;
  localparam int unsigned ST_CPL_BIT = 6;
  localparam int unsigned ST_RES_LO  = 8;
  localparam int unsigned ST_RES_HI  = 15;
  localparam int unsigned ST_LEN_LO  = 16;
  localparam int unsigned ST_LEN_HI  = 31;

  // command qword field positions
  localparam int unsigned CMD_OP_LO  = 0;
  localparam int unsigned CMD_OP_HI  = 7;
  localparam int unsigned CMD_FID_LO = 40;
  localparam int unsigned FID_W      = 9;

  localparam logic [7:0]  OP_GET_STATE  = 8'h10;
  localparam logic [15:0] LEN_GET_STATE = 16'd2;

  localparam logic [7:0] RES_OK      = 8'h40;
  localparam logic [7:0] RES_BAD_OP  = 8'h01;
  localparam logic [7:0] RES_NO_FEAT = 8'h02;
  localparam logic [7:0] RES_BAD_LEN = 8'h03;

  localparam logic [1:0] OWN_NONE = 2'd0;
  localparam logic [1:0] OWN_HOST = 2'd1;

  typedef enum logic [1:0] {
    MB_FREE = 2'd0,
    MB_HELD = 2'd1,
    MB_RUN  = 2'd2
  } mb_state_e;

  typedef struct packed {
    logic locked;
    logic oob_sel;
    logic rd_blk;
    logic wr_blk;
    logic enabled;
  } feat_flags_t;

  function automatic logic [31:0] pack_resp(feat_flags_t f, logic [7:0] fid);
    logic [31:0] w;
    w       = '0;
    w[0]    = f.enabled;
    w[4]    = f.wr_blk;
    w[5]    = f.rd_blk;
    w[6]    = f.oob_sel;
    w[15:8] = fid;
    w[31]   = f.locked;
    return w;
  endfunction

endpackage

// File: rtl/featstat_table.sv
module featstat_table
  import featstat_pkg::*;
#(
  parameter int unsigned NUM_FEAT = 8,
  localparam int unsigned IDX_W = (NUM_FEAT > 1) ? $clog2(NUM_FEAT) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_we,
  input  logic [IDX_W-1:0] cfg_idx,
  input  logic             cfg_valid,
  input  feat_flags_t      cfg_flags,
  input  logic [FID_W-1:0] lk_fid,
  output logic             lk_hit,
  output feat_flags_t      lk_flags
);

  logic [NUM_FEAT-1:0] valid_vec;
  feat_flags_t         flags_arr [NUM_FEAT];

  for (genvar g = 0; g < NUM_FEAT; g++) begin : g_entry
    logic        ent_en;
    logic        v_q;
    feat_flags_t f_q;

    assign ent_en = cfg_we && (cfg_idx == IDX_W'(g));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        v_q <= 1'b0;
        f_q <= '0;
      end else if (ent_en) begin
        v_q <= cfg_valid;
        f_q <= cfg_flags;
      end
    end

    assign valid_vec[g] = v_q;
    assign flags_arr[g] = f_q;
  end

  // full-width compare: IDs at or above NUM_FEAT never hit
  always_comb begin
    lk_hit   = 1'b0;
    lk_flags = '0;
    for (int i = 0; i < NUM_FEAT; i++) begin
      if (lk_fid == FID_W'(i)) begin
        lk_hit   = valid_vec[i];
        lk_flags = flags_arr[i];
      end
    end
  end

endmodule

// File: rtl/featstat_engine.sv
module featstat_engine
  import featstat_pkg::*;
#(
  parameter int unsigned LATENCY = 8,
  localparam int unsigned CNT_W = $clog2(LATENCY + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_cmd,
  input  logic              wr_stat,
  input  logic [BUS_DW-1:0] wdata,
  input  logic              lk_hit,
  input  feat_flags_t       lk_flags,
  output logic [FID_W-1:0]  lk_fid,
  output logic              busy,
  output logic [1:0]        owner,
  output logic [BUS_DW-1:0] cmd_q,
  output logic [15:0]       len_q,
  output logic [7:0]        result_q,
  output logic [31:0]       resp_q
);

  mb_state_e        state_q, state_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             cnt_en;
  logic             cmd_en;
  logic             len_en;
  logic [15:0]      len_d;
  logic             post_en;
  logic [7:0]       result_d;
  logic [31:0]      resp_d;
  logic [7:0]       verdict;
  logic [31:0]      verdict_resp;

  assign lk_fid = cmd_q[CMD_FID_LO +: FID_W];
  assign busy   = (state_q == MB_RUN);
  assign owner  = (state_q == MB_FREE) ? OWN_NONE : OWN_HOST;

  // outcome of the lookup, checked in priority order
  always_comb begin
    verdict      = RES_OK;
    verdict_resp = '0;
    if (len_q != LEN_GET_STATE) begin
      verdict = RES_BAD_LEN;
    end else if (cmd_q[CMD_OP_HI:CMD_OP_LO] != OP_GET_STATE) begin
      verdict = RES_BAD_OP;
    end else if (!lk_hit) begin
      verdict = RES_NO_FEAT;
    end else begin
      verdict_resp = pack_resp(lk_flags, lk_fid[7:0]);
    end
  end

  // next-state logic
  always_comb begin
    state_d  = state_q;
    cnt_d    = cnt_q;
    cnt_en   = 1'b0;
    cmd_en   = 1'b0;
    len_en   = 1'b0;
    len_d    = len_q;
    post_en  = 1'b0;
    result_d = result_q;
    resp_d   = resp_q;
    unique case (state_q)
      MB_FREE: begin
        if (wr_cmd) begin
          cmd_en  = 1'b1;
          state_d = MB_HELD;
        end
      end
      MB_HELD: begin
        if (wr_stat) begin
          if (wdata[ST_CPL_BIT]) begin
            state_d  = MB_FREE;
            len_en   = 1'b1;
            len_d    = '0;
            post_en  = 1'b1;
            result_d = '0;
            resp_d   = '0;
          end else if (wdata[ST_RB_BIT]) begin
            state_d  = MB_RUN;
            cnt_en   = 1'b1;
            cnt_d    = CNT_W'(LATENCY);
            len_en   = 1'b1;
            len_d    = wdata[ST_LEN_HI:ST_LEN_LO];
            post_en  = 1'b1;
            result_d = '0;
            resp_d   = '0;
          end
        end
      end
      MB_RUN: begin
        cnt_en = 1'b1;
        cnt_d  = cnt_q - 1'b1;
        if (cnt_q == CNT_W'(2)) begin
          post_en  = 1'b1;
          result_d = verdict;
          resp_d   = verdict_resp;
        end
        if (cnt_q == CNT_W'(1)) begin
          state_d = MB_HELD;
        end
      end
      default: state_d = MB_FREE;
    endcase
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= MB_FREE;
    end else begin
      state_q <= state_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (cnt_en) begin
      cnt_q <= cnt_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmd_q <= '0;
    end else if (cmd_en) begin
      cmd_q <= wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      len_q <= '0;
    end else if (len_en) begin
      len_q <= len_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      result_q <= '0;
      resp_q   <= '0;
    end else if (post_en) begin
      result_q <= result_d;
      resp_q   <= resp_d;
    end
  end

endmodule

// File: rtl/featstat_regif.sv
module featstat_regif
  import featstat_pkg::*;
(
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [BUS_AW-1:0] bus_addr,
  input  logic              busy,
  input  logic [1:0]        owner,
  input  logic [15:0]       len_q,
  input  logic [7:0]        result_q,
  input  logic [BUS_DW-1:0] cmd_q,
  input  logic [31:0]       resp_q,
  output logic              wr_cmd,
  output logic              wr_stat,
  output logic [BUS_DW-1:0] rdata
);

  logic [BUS_DW-1:0] stat_word;

  assign wr_cmd  = bus_wr && (bus_addr == OFS_CMD);
  assign wr_stat = bus_wr && (bus_addr == OFS_STAT);

  always_comb begin
    stat_word                       = '0;
    stat_word[ST_RB_BIT]            = busy;
    stat_word[ST_OWN_HI:ST_OWN_LO]  = owner;
    stat_word[ST_RES_HI:ST_RES_LO]  = result_q;
    stat_word[ST_LEN_HI:ST_LEN_LO]  = len_q;
  end

  always_comb begin
    rdata = '0;
    if (bus_rd) begin
      case (bus_addr)
        OFS_STAT: rdata = stat_word;
        OFS_CMD:  rdata = cmd_q;
        OFS_RESP: rdata = {32'h0, resp_q};
        default:  rdata = '0;
      endcase
    end
  end

endmodule

// File: rtl/featstat_mbox.sv
module featstat_mbox
  import featstat_pkg::*;
#(
  parameter int unsigned NUM_FEAT = 8,
  parameter int unsigned LATENCY  = 8,
  localparam int unsigned IDX_W = (NUM_FEAT > 1) ? $clog2(NUM_FEAT) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bus_wr,
  input  logic             bus_rd,
  input  logic [7:0]       bus_addr,
  input  logic [63:0]      bus_wdata,
  output logic [63:0]      bus_rdata,
  input  logic             cfg_we,
  input  logic [IDX_W-1:0] cfg_idx,
  input  logic             cfg_valid,
  input  logic [4:0]       cfg_flags
);

  // reset release synchroniser
  logic rst_meta_q;
  logic rst_sync_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sync_n <= rst_meta_q;
    end
  end

  logic              wr_cmd;
  logic              wr_stat;
  logic [FID_W-1:0]  lk_fid;
  logic              lk_hit;
  feat_flags_t       lk_flags;
  logic              eng_busy;
  logic [1:0]        eng_owner;
  logic [BUS_DW-1:0] eng_cmd;
  logic [15:0]       eng_len;
  logic [7:0]        eng_result;
  logic [31:0]       eng_resp;

  featstat_regif u_regif (
    .bus_wr   (bus_wr),
    .bus_rd   (bus_rd),
    .bus_addr (bus_addr),
    .busy     (eng_busy),
    .owner    (eng_owner),
    .len_q    (eng_len),
    .result_q (eng_result),
    .cmd_q    (eng_cmd),
    .resp_q   (eng_resp),
    .wr_cmd   (wr_cmd),
    .wr_stat  (wr_stat),
    .rdata    (bus_rdata)
  );

  featstat_engine #(
    .LATENCY (LATENCY)
  ) u_engine (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .wr_cmd   (wr_cmd),
    .wr_stat  (wr_stat),
    .wdata    (bus_wdata),
    .lk_hit   (lk_hit),
    .lk_flags (lk_flags),
    .lk_fid   (lk_fid),
    .busy     (eng_busy),
    .owner    (eng_owner),
    .cmd_q    (eng_cmd),
    .len_q    (eng_len),
    .result_q (eng_result),
    .resp_q   (eng_resp)
  );

  featstat_table #(
    .NUM_FEAT (NUM_FEAT)
  ) u_table (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .cfg_we    (cfg_we),
    .cfg_idx   (cfg_idx),
    .cfg_valid (cfg_valid),
    .cfg_flags (feat_flags_t'(cfg_flags)),
    .lk_fid    (lk_fid),
    .lk_hit    (lk_hit),
    .lk_flags  (lk_flags)
  );

endmodule

// File: rtl/featstat_mbox_chk.sv
module featstat_mbox_chk
  import featstat_pkg::*;
#(
  parameter int unsigned LATENCY = 8
) (
  input logic        clk,
  input logic        rst_n,
  input logic        bus_wr,
  input logic [7:0]  bus_addr,
  input logic [63:0] bus_wdata,
  input logic        busy,
  input logic [1:0]  owner,
  input logic [7:0]  result,
  input logic [31:0] resp,
  input logic [63:0] cmd
);

  logic [31:0] busy_run;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_run <= '0;
    end else if (busy) begin
      busy_run <= busy_run + 1'b1;
    end else begin
      busy_run <= '0;
    end
  end

  AST_CMD_TAKES_OWNER: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == OFS_CMD && owner == OWN_NONE) |=> (owner == OWN_HOST && cmd == $past(bus_wdata))); // R2

  AST_CMD_IGNORED_WHEN_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == OFS_CMD && owner != OWN_NONE) |=> $stable(cmd)); // R3

  AST_BUSY_NEEDS_HOST: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> owner == OWN_HOST); // R4

  AST_RESULT_SETTLED: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> ($stable(resp) && $stable(result))); // R5

  AST_BUSY_BOUNDED: assert property (@(posedge clk) disable iff (!rst_n)
    busy_run <= LATENCY); // R5

  AST_OK_ECHOES_ID: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && owner == OWN_HOST && result == RES_OK) |-> resp[15:8] == cmd[47:40]); // R7

  AST_CPL_FREES: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == OFS_STAT && bus_wdata[ST_CPL_BIT] && !busy && owner == OWN_HOST)
    |=> (owner == OWN_NONE && result == 8'h00 && resp == 32'h0)); // R9

  AST_OWNER_CODE: assert property (@(posedge clk) disable iff (!rst_n)
    (owner == OWN_NONE || owner == OWN_HOST)); // R11

endmodule

bind featstat_mbox featstat_mbox_chk #(.LATENCY(LATENCY)) u_chk (
  .clk       (clk),
  .rst_n     (rst_sync_n),
  .bus_wr    (bus_wr),
  .bus_addr  (bus_addr),
  .bus_wdata (bus_wdata),
  .busy      (eng_busy),
  .owner     (eng_owner),
  .result    (eng_result),
  .resp      (eng_resp),
  .cmd       (eng_cmd)
);

// File: tb/featstat_mbox_test.sv
`timescale 1ns/1ps
module featstat_mbox_test;

  localparam int NF  = 8;
  localparam int LAT = 8;

  logic        clk;
  logic        rst_n;
  logic        bus_wr;
  logic        bus_rd;
  logic [7:0]  bus_addr;
  logic [63:0] bus_wdata;
  logic [63:0] bus_rdata;
  logic        cfg_we;
  logic [2:0]  cfg_idx;
  logic        cfg_valid;
  logic [4:0]  cfg_flags;

  featstat_mbox #(.NUM_FEAT(NF), .LATENCY(LAT)) uut (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .cfg_we(cfg_we), .cfg_idx(cfg_idx),
    .cfg_valid(cfg_valid), .cfg_flags(cfg_flags)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  int checks = 0;
  int fails  = 0;
  bit reported = 1'b0;
  bit mon_on = 1'b0;

  task automatic chk(input string tag, input logic [63:0] got, input logic [63:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, got, exp);
    end
  endtask

  task automatic report();
    if (!reported) begin
      reported = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    end
  endtask

  // ---------------- behavioural reference model ----------------
  int          m_sync;
  int          m_own, m_rb, m_cnt;
  logic [63:0] m_cmd;
  logic [15:0] m_len;
  logic [7:0]  m_res;
  logic [31:0] m_resp;
  bit          m_val [NF];
  logic [4:0]  m_fl  [NF];

  task automatic m_clear();
    m_own = 0; m_rb = 0; m_cnt = 0; m_cmd = '0; m_len = '0; m_res = '0; m_resp = '0;
    for (int i = 0; i < NF; i++) begin m_val[i] = 1'b0; m_fl[i] = '0; end
  endtask

  task automatic m_post();
    int fid;
    fid = int'(m_cmd[48:40]);
    m_resp = '0;
    if (m_len != 16'd2) m_res = 8'h03;
    else if (m_cmd[7:0] != 8'h10) m_res = 8'h01;
    else if (fid >= NF || !m_val[fid]) m_res = 8'h02;
    else begin
      m_res = 8'h40;
      m_resp = {m_fl[fid][4], 15'h0, m_cmd[47:40], 1'b0, m_fl[fid][3], m_fl[fid][2], m_fl[fid][1], 3'b000, m_fl[fid][0]};
    end
  endtask

  always @(posedge clk) begin
    if (!rst_n) begin
      m_sync = 0; m_clear();
    end else if (m_sync < 2) begin
      m_sync++; m_clear();
    end else begin
      if (m_rb != 0) begin
        if (m_cnt == 2) m_post();
        if (m_cnt == 1) m_rb = 0;
        m_cnt--;
      end else if (bus_wr) begin
        if (bus_addr == 8'h08 && m_own == 0) begin
          m_cmd = bus_wdata; m_own = 1;
        end else if (bus_addr == 8'h00 && m_own == 1) begin
          if (bus_wdata[6]) begin
            m_own = 0; m_len = '0; m_res = '0; m_resp = '0;
          end else if (bus_wdata[0]) begin
            m_rb = 1; m_cnt = LAT; m_len = bus_wdata[31:16]; m_res = '0; m_resp = '0;
          end
        end
      end
      if (cfg_we && int'(cfg_idx) < NF) begin
        m_val[cfg_idx] = cfg_valid; m_fl[cfg_idx] = cfg_flags;
      end
    end
  end

  function automatic logic [63:0] m_read(logic rd, logic [7:0] a);
    if (!rd) return 64'h0;
    case (a)
      8'h00:   return {32'h0, m_len, m_res, 2'b00, 2'(m_own), 3'b000, 1'(m_rb)};
      8'h08:   return m_cmd;
      8'h0C:   return {32'h0, m_resp};
      default: return 64'h0;
    endcase
  endfunction

  // per-cycle comparison against the model (R4, R5, R11)
  always @(negedge clk) begin
    if (mon_on) chk("R4/R5 model compare", bus_rdata, m_read(bus_rd, bus_addr));
  end

  // ---------------- stimulus helpers ----------------
  task automatic bwrite(input logic [7:0] a, input logic [63:0] d);
    @(negedge clk); #1;
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk); #1;
    bus_wr = 1'b0; bus_addr = 8'h00; bus_wdata = '0;
  endtask

  task automatic bread(input logic [7:0] a, input logic rd, output logic [63:0] d);
    @(negedge clk); #1;
    bus_addr = a; bus_rd = rd;
    #1;
    d = bus_rdata;
    bus_addr = 8'h00; bus_rd = 1'b1;
  endtask

  task automatic cfg(input int idx, input logic v, input logic [4:0] f);
    @(negedge clk); #1;
    cfg_we = 1'b1; cfg_idx = 3'(idx); cfg_valid = v; cfg_flags = f;
    @(negedge clk); #1;
    cfg_we = 1'b0;
  endtask

  task automatic run_get(input logic [8:0] fid, input logic [7:0] op, input logic [15:0] len,
                         output logic [7:0] res, output logic [31:0] resp, output int busy_reads);
    logic [63:0] d;
    bwrite(8'h08, (64'(fid) << 40) | 64'(op));
    bwrite(8'h00, {32'h0, len, 16'h0001});
    busy_reads = 0;
    bread(8'h00, 1'b1, d);
    while (d[0]) begin
      busy_reads++;
      bread(8'h00, 1'b1, d);
    end
    res = d[15:8];
    bread(8'h0C, 1'b1, d);
    resp = d[31:0];
  endtask

  task automatic complete();
    bwrite(8'h00, 64'h40);
  endtask

  // ---------------- test sequence ----------------
  initial begin
    logic [63:0] d;
    logic [7:0]  res;
    logic [31:0] resp;
    int          nb;

    rst_n = 1'b0; bus_wr = 1'b0; bus_rd = 1'b1; bus_addr = 8'h00; bus_wdata = '0;
    cfg_we = 1'b0; cfg_idx = '0; cfg_valid = 1'b0; cfg_flags = '0;
    repeat (4) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
    repeat (5) @(posedge clk);
    mon_on = 1'b1;

    // R1 reset values
    bread(8'h00, 1'b1, d); chk("R1 status after reset", d, 64'h0);
    bread(8'h08, 1'b1, d); chk("R1 command after reset", d, 64'h0);
    bread(8'h0C, 1'b1, d); chk("R1 response after reset", d, 64'h0);

    // R10 table load
    cfg(0, 1'b1, 5'b11111);
    cfg(3, 1'b1, 5'b10001);
    cfg(5, 1'b0, 5'b00001);
    cfg(7, 1'b1, 5'b01100);

    // R3 run-busy before ownership is ignored
    bwrite(8'h00, {32'h0, 16'd2, 16'h0001});
    bread(8'h00, 1'b1, d); chk("R3 run-busy without owner ignored", d, 64'h0);

    // R2 command claims ownership, R3 second command ignored
    bwrite(8'h08, (64'd3 << 40) | 64'h10);
    bread(8'h00, 1'b1, d); chk("R2 owner field in-band", 64'(d[5:4]), 64'd1);
    bwrite(8'h08, (64'd7 << 40) | 64'h10);
    bread(8'h08, 1'b1, d); chk("R3 second command ignored", d, (64'd3 << 40) | 64'h10);
    complete();
    bread(8'h00, 1'b1, d); chk("R9 completion frees owner", d, 64'h0);

    // R6 R7 success cases
    run_get(9'd3, 8'h10, 16'd2, res, resp, nb);
    chk("R5 busy duration", 64'(nb), 64'(LAT - 1));
    chk("R6 result fid3", 64'(res), 64'h40);
    chk("R7 response fid3", 64'(resp), 64'h8000_0301);
    bread(8'h00, 1'b1, d); chk("R11 status layout after success", d, 64'h0000_0000_0002_4010);
    complete();

    run_get(9'd0, 8'h10, 16'd2, res, resp, nb);
    chk("R6 result fid0", 64'(res), 64'h40);
    chk("R7 response fid0 all flags", 64'(resp), 64'h8000_0071);
    complete();

    run_get(9'd7, 8'h10, 16'd2, res, resp, nb);
    chk("R7 response fid7", 64'(resp), 64'h0000_0760);
    complete();

    // R8 failures
    run_get(9'd5, 8'h10, 16'd2, res, resp, nb);
    chk("R8 absent entry code", 64'(res), 64'h02);
    chk("R8 absent entry response", 64'(resp), 64'h0);
    complete();
    run_get(9'd8, 8'h10, 16'd2, res, resp, nb);
    chk("R8 id past table", 64'(res), 64'h02);
    complete();
    run_get(9'h103, 8'h10, 16'd2, res, resp, nb);
    chk("R8 id with high bit", 64'(res), 64'h02);
    chk("R8 id with high bit response", 64'(resp), 64'h0);
    complete();
    run_get(9'd3, 8'h11, 16'd2, res, resp, nb);
    chk("R8 bad opcode", 64'(res), 64'h01);
    complete();
    run_get(9'd3, 8'h10, 16'd3, res, resp, nb);
    chk("R8 bad length", 64'(res), 64'h03);
    complete();
    run_get(9'd5, 8'h22, 16'd1, res, resp, nb);
    chk("R8 length before opcode priority", 64'(res), 64'h03);
    complete();

    // R3 completion while busy is ignored
    bwrite(8'h08, (64'd3 << 40) | 64'h10);
    bwrite(8'h00, {32'h0, 16'd2, 16'h0001});
    bwrite(8'h00, 64'h40);
    bread(8'h00, 1'b1, d); chk("R3 completion during busy ignored", 64'(d[5:0]), 64'h11);
    repeat (LAT + 2) @(posedge clk);
    bread(8'h00, 1'b1, d); chk("R5 busy cleared with result", d, 64'h0000_0000_0002_4010);

    // R9 completion wins over run-busy in one write
    bwrite(8'h00, {32'h0, 16'd2, 16'h0041});
    bread(8'h00, 1'b1, d); chk("R9 completion priority", d, 64'h0);
    bread(8'h0C, 1'b1, d); chk("R9 response cleared", d, 64'h0);

    // R10 reconfiguration takes effect
    cfg(3, 1'b1, 5'b00000);
    run_get(9'd3, 8'h10, 16'd2, res, resp, nb);
    chk("R10 updated flags", 64'(resp), 64'h0000_0300);
    complete();
    cfg(0, 1'b0, 5'b11111);
    run_get(9'd0, 8'h10, 16'd2, res, resp, nb);
    chk("R10 removed entry", 64'(res), 64'h02);
    complete();

    // R11 read decode
    bread(8'h10, 1'b1, d); chk("R11 unmapped offset", d, 64'h0);
    bread(8'h08, 1'b0, d); chk("R11 read strobe low", d, 64'h0);

    repeat (3) @(posedge clk);
    mon_on = 1'b0;
    report();
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog expired: actual=running expected=finished");
    report();
    $finish;
  end

endmodule